// File: doc/BRIEF.md
# Edge-Kick Watchdog Timer

This block supervises a processor by watching a single kick line. Software keeps the watchdog satisfied by toggling that line. A rising transition and a falling transition both count as a kick, and each one restarts the timeout count. If the line stays at either level for the full timeout, the active-low watchdog output drops. It stays low until the timer is next cleared. The output can be wired back to a manual-reset input so that a stalled processor gets a reset pulse.

The timer is held cleared in several cases:
- while the system reset from the reset generator is asserted;
- while an external detector reports that the kick line is undriven (three-stated or floating);
- while the supply-good flag is low.

While the supply is low, the output is forced low without delay. When the supply recovers, the output returns high in the same time step, without waiting for a clock edge.

The timeout length is computed from the clock frequency and a timeout in milliseconds. The default is 1.6 s at 125 MHz. All pins are plain level signals with no handshake. The kick line and the undriven flag pass through a two-stage synchronizer. A kick edge is found by comparing the synchronized kick with a registered copy of it.

Top module: `kick_watchdog`

## Requirements
- R1: With no clearing condition present, the output goes low on the TIMEOUT_CYCLES-th rising clock edge after counting begins. This holds whether the kick line rests high or low. TIMEOUT_CYCLES = CLK_HZ/1000*TIMEOUT_MS. After sys_reset_i is released, the first counting edge is the first rising edge at which sys_reset_i is low.
- R2: A rising or a falling change on kick_i clears the count on the third rising clock edge after the change. With no further kick, the output then falls on the (TIMEOUT_CYCLES+3)-th rising edge after the change.
- R3: Once low because of a timeout, the output stays low for as long as no clearing condition occurs.
- R4: When a kick clears an expired timer, the output returns high on the same clock edge that clears the count. That edge is the third rising edge after the kick change.
- R5: While sys_reset_i is high, the timer is cleared at every rising edge. The output is high from the first rising edge of the reset onward, however long the reset lasts.
- R6: A high level on kick_float_i clears the timer on the third rising edge after it is set. The timer then stays cleared and the output stays high, even if the kick line toggles. Counting resumes after the flag is released, and the output falls on the (TIMEOUT_CYCLES+2)-th rising edge after the release.
- R7: While supply_ok_i is low, wdog_n_o is low with no clock delay, whether or not the timer has expired.
- R8: A low supply_ok_i clears the timer at each rising edge. When supply_ok_i returns high, wdog_n_o goes high in the same time step, and the next timeout expires TIMEOUT_CYCLES rising edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| kick_i | input | 1 | Kick line from the processor, asynchronous |
| kick_float_i | input | 1 | High while the kick line is undriven; asynchronous |
| sys_reset_i | input | 1 | System reset state from the reset generator, active high, synchronous to clk_i |
| supply_ok_i | input | 1 | High while the supply is above its threshold |
| wdog_n_o | output | 1 | Watchdog output, low on timeout or low supply |

## Verification
The results arrive with different latencies:
- The supply path is combinational, so the bench checks the output one nanosecond after it changes supply_ok_i, with no clock edge in between.
- The system reset takes effect at the first rising edge.
- A kick change or an undriven flag takes effect at the third rising edge, because of the two synchronizer stages and the edge register.
- A timeout falls exactly TIMEOUT_CYCLES counting edges after the last clear.

The bench drives inputs on falling edges and samples one nanosecond after rising edges. For each latency it checks the output one edge before the expected change, where the old value must still hold, and again on the edge itself.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // Index of each asynchronous input inside the synchronizer word.
  localparam int unsigned KWD_KICK  = 0;
  localparam int unsigned KWD_FLOAT = 1;
  localparam int unsigned KWD_NSYNC = 2;

  // Clock cycles in a timeout of ms milliseconds at hz.
  function automatic int unsigned kwd_cycles(input int unsigned hz, input int unsigned ms);
    return (hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/kwd_sync.sv
module kwd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk_i) pipe[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) pipe[s] <= pipe[s-1];
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/kwd_edge.sv
module kwd_edge (
  input  logic clk_i,
  input  logic lvl_i,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk_i) lvl_q <= lvl_i;

  // Either direction of change counts.
  assign edge_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer #(
  parameter int unsigned LIMIT = 100,
  parameter int unsigned CNT_W = $clog2(LIMIT)
) (
  input  logic             clk_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == LAST) exp_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import kwd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned TIMEOUT_MS  = 1600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic kick_i,
  input  logic kick_float_i,
  input  logic sys_reset_i,
  input  logic supply_ok_i,
  output logic wdog_n_o
);
  localparam int unsigned TIMEOUT_CYCLES = kwd_cycles(CLK_HZ, TIMEOUT_MS);
  localparam int unsigned CNT_W          = $clog2(TIMEOUT_CYCLES);

  logic [KWD_NSYNC-1:0] raw;
  logic [KWD_NSYNC-1:0] synced;
  logic                 kick_edge;
  logic                 float_s;
  logic                 timer_clr;
  logic [CNT_W-1:0]     cnt;
  logic                 expired;

  always_comb begin
    raw            = '0;
    raw[KWD_KICK]  = kick_i;
    raw[KWD_FLOAT] = kick_float_i;
  end

  kwd_sync #(.WIDTH(KWD_NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (raw),
    .q_o   (synced)
  );

  kwd_edge u_edge (
    .clk_i  (clk_i),
    .lvl_i  (synced[KWD_KICK]),
    .edge_o (kick_edge)
  );

  assign float_s   = synced[KWD_FLOAT];
  assign timer_clr = sys_reset_i | float_s | ~supply_ok_i | kick_edge;

  kwd_timer #(.LIMIT(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .clr_i     (timer_clr),
    .cnt_o     (cnt),
    .expired_o (expired)
  );

  // Low supply forces the output low with no clock delay.
  assign wdog_n_o = supply_ok_i & ~expired;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int unsigned LIMIT = 100,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             sys_reset_i,
  input logic             supply_ok_i,
  input logic             wdog_n_o,
  input logic             clr_i,
  input logic             float_s_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             expired_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  assert_count_up_R1: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    (!clr_i && !expired_i && cnt_i != LAST) |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_expire_R1: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    (!clr_i && !expired_i && cnt_i == LAST) |=> expired_i);

  assert_latched_low_R3: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    (expired_i && !clr_i) |=> (expired_i && !wdog_n_o));

  assert_clear_release_R4: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    clr_i |=> (!expired_i && cnt_i == '0));

  assert_reset_clears_R5: assert property (@(posedge clk_i)
    sys_reset_i |=> (!expired_i && cnt_i == '0));

  assert_float_high_R6: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    (float_s_i && supply_ok_i) |=> (wdog_n_o || !supply_ok_i));

  assert_supply_low_R7: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    !supply_ok_i |-> !wdog_n_o);

  assert_supply_clears_R8: assert property (@(posedge clk_i) disable iff (sys_reset_i)
    !supply_ok_i |=> !expired_i);
endmodule

bind kick_watchdog kwd_checker #(.LIMIT(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_kwd_checker (
  .clk_i       (clk_i),
  .sys_reset_i (sys_reset_i),
  .supply_ok_i (supply_ok_i),
  .wdog_n_o    (wdog_n_o),
  .clr_i       (timer_clr),
  .float_s_i   (float_s),
  .cnt_i       (cnt),
  .expired_i   (expired)
);

// File: tb/test_kick_watchdog.sv
`timescale 1ns/1ps
module test_kick_watchdog;
  localparam int unsigned CLK_HZ = 25_000;
  localparam int unsigned TO_MS  = 4;
  localparam int          LIM    = (CLK_HZ / 1000) * TO_MS;

  logic clk = 1'b0;
  logic kick, kfloat, sreset, supply;
  logic wdog_n;
  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  kick_watchdog #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TO_MS)) i_kick_watchdog (
    .clk_i        (clk),
    .kick_i       (kick),
    .kick_float_i (kfloat),
    .sys_reset_i  (sreset),
    .supply_ok_i  (supply),
    .wdog_n_o     (wdog_n)
  );

  task automatic check(input string req, input logic exp);
    total++;
    if (wdog_n !== exp) begin
      bad++;
      $display("FAIL %s: wdog_n actual=%b expected=%b at %0t", req, wdog_n, exp, $time);
    end
  endtask

  // Advance n rising edges, then sample 1 ns later.
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state_R5;
    kick = 0; kfloat = 0; sreset = 1; supply = 1;
    edges(5);
    check("R5 reset state", 1'b1);
  endtask

  task automatic t_timeout_low_R1;
    @(negedge clk) sreset = 0;
    edges(LIM - 1);
    check("R1 low level, one edge early", 1'b1);
    edges(1);
    check("R1 low level, expiry edge", 1'b0);
  endtask

  task automatic t_latch_R3;
    edges(25);
    check("R3 stays low", 1'b0);
  endtask

  task automatic t_kick_recover_R4;
    @(negedge clk) kick = 1;
    edges(2);
    check("R4 still low before clear", 1'b0);
    edges(1);
    check("R4 high on clearing edge", 1'b1);
    edges(LIM - 1);
    check("R1 high level, one edge early", 1'b1);
    edges(1);
    check("R1 high level, expiry edge", 1'b0);
  endtask

  task automatic t_kick_restart_R2;
    @(negedge clk) kick = 0;
    edges(3);
    check("R2 falling kick recovers", 1'b1);
    edges(LIM / 2);
    @(negedge clk) kick = 1;
    edges(LIM + 2);
    check("R2 restart, one edge early", 1'b1);
    edges(1);
    check("R2 restart, expiry edge", 1'b0);
  endtask

  task automatic t_sys_reset_R5;
    @(negedge clk) sreset = 1;
    edges(1);
    check("R5 first reset edge", 1'b1);
    edges(3 * LIM);
    check("R5 long reset", 1'b1);
    @(negedge clk) sreset = 0;
    edges(LIM - 1);
    check("R1 after reset, one edge early", 1'b1);
    edges(1);
    check("R1 after reset, expiry edge", 1'b0);
  endtask

  task automatic t_float_R6;
    @(negedge clk) kfloat = 1;
    edges(2);
    check("R6 before float clear", 1'b0);
    edges(1);
    check("R6 float clear edge", 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) kick = ~kick;
      edges(7);
    end
    edges(2 * LIM);
    check("R6 float holds high", 1'b1);
    @(negedge clk) kfloat = 0;
    edges(LIM + 1);
    check("R6 resume, one edge early", 1'b1);
    edges(1);
    check("R6 resume, expiry edge", 1'b0);
  endtask

  task automatic t_supply_R7_R8;
    @(negedge clk) kick = ~kick;
    edges(3);
    check("R4 recover before supply test", 1'b1);
    edges(5);
    @(negedge clk) supply = 0;
    #1;
    check("R7 low without clock", 1'b0);
    edges(LIM + 10);
    check("R7 held low", 1'b0);
    @(negedge clk) supply = 1;
    #1;
    check("R8 high without clock", 1'b1);
    edges(LIM - 1);
    check("R8 restart, one edge early", 1'b1);
    edges(1);
    check("R8 restart, expiry edge", 1'b0);
  endtask

  initial begin
    t_reset_state_R5();
    t_timeout_low_R1();
    t_latch_R3();
    t_kick_recover_R4();
    t_kick_restart_R2();
    t_sys_reset_R5();
    t_float_R6();
    t_supply_R7_R8();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50_000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule